// File: doc/BRIEF.md
# Pipelined No-Turnaround Synchronous SRAM

A synthesizable model of a pipelined synchronous SRAM. Reads and writes mix freely, cycle after cycle, with no idle slot between them. Every command is sampled on a rising clock edge. A read returns its data from an output register two edges after the command. A write takes its data two edges after its address, so a write uses the data bus in the same slot a read would have used.

The word is split into byte lanes of 9 bits each, and each lane has its own active-low write enable. Three chip selects gate new commands. A burst input steps the low two address bits in linear or interleaved order. An active-low clock enable freezes the whole block. Output enable and sleep act on the data outputs at once, with no clock. The data bus is modelled as `q_o` with a drive flag `q_en_o`. "Tristated" means `q_en_o` = 0 and `q_o` = 0.

Top module: `nt_sram`

## Requirements
- R1: A read sampled at edge n puts the stored word on `q_o` with `q_en_o` = 1 after edge n+2. A slot belonging to a write leaves the bus tristated.
- R2: A write sampled at edge n stores the `d_i` value sampled at edge n+2. Reads and writes may follow each other on every cycle, and a read sees every write sampled before it.
- R3: Lane k is bits [9k+8:9k]. When `bw_ni[k]` = 0 on a write, that lane is written. When it is 1, the lane keeps its old contents.
- R4: A load cycle is accepted only when `ce0_ni` = 0, `ce1_i` = 1 and `ce2_ni` = 0. Any other load cycle is a bubble, and the bus is tristated in its slot.
- R5: While `cke_ni` = 1, clock edges are ignored. No command is accepted, no write completes, and the bus outputs hold.
- R6: `oe_ni` = 1 tristates the bus at once, with no clock edge needed. Clearing it restores the held read data.
- R7: `sleep_i` = 1 tristates the bus at once. Any command sampled while it is high is dropped.
- R8: `adv_i` = 1 repeats the last loaded operation at the next burst address. The upper address bits stay fixed. The low two bits are (base+k) mod 4 when `lin_burst_i` = 1, or base XOR k when it is 0, where k is the beat number starting at 0. An advance that follows a bubble is itself a bubble.
- R9: After reset the bus is tristated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cke_ni | input | 1 | Clock enable, active low |
| ce0_ni | input | 1 | Chip select, active low |
| ce1_i | input | 1 | Chip select, active high |
| ce2_ni | input | 1 | Chip select, active low |
| adv_i | input | 1 | 1 = advance burst, 0 = load new address |
| we_ni | input | 1 | 0 = write, 1 = read (on load) |
| bw_ni | input | LANES | Per-lane write enable, active low |
| addr_i | input | ADDR_W | Word address |
| lin_burst_i | input | 1 | Burst order: 1 linear, 0 interleaved |
| d_i | input | LANES*LANE_W | Write data, two edges after its address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Asynchronous power-down |
| q_o | output | LANES*LANE_W | Read data, zero when not driven |
| q_en_o | output | 1 | Bus drive enable |

## Verification
The assertions check on every cycle that a suspended edge leaves the pipeline and the output register unchanged. They also check that deselected or sleeping cycles insert bubbles, that a write slot never drives the bus, and that the array never reads and writes in the same edge. Only the bench scenarios can show data correctness: lane merging, read-after-write ordering across mixed traffic, the two burst orders, and the immediate effect of output enable and sleep on held data.

// File: rtl/nt_sram_pkg.sv
package nt_sram_pkg;
  typedef enum logic {ORD_INTERLEAVE = 1'b0, ORD_LINEAR = 1'b1} burst_ord_e;

  function automatic logic [1:0] burst_lo(input logic [1:0] base, input logic [1:0] beat,
                                          input burst_ord_e ord);
    return (ord == ORD_LINEAR) ? base + beat : base ^ beat;
  endfunction
endpackage

// File: rtl/nt_sram_burst.sv
module nt_sram_burst
  import nt_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic              linear_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  logic [ADDR_W-1:0] base_q;
  logic [1:0]        beat_q;
  burst_ord_e        ord;

  assign ord    = linear_i ? ORD_LINEAR : ORD_INTERLEAVE;
  assign addr_o = load_i ? addr_i
                         : {base_q[ADDR_W-1:2], burst_lo(base_q[1:0], beat_q, ord)};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (en_i) begin
      if (load_i) begin
        base_q <= addr_i;
        beat_q <= 2'd1;
      end else if (adv_i) begin
        beat_q <= beat_q + 2'd1;
      end
    end
  end
endmodule

// File: rtl/nt_sram_array.sv
module nt_sram_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [LANES-1:0]  wr_be_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_q_o
);
  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_be_i[l])
        mem[wr_addr_i][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
    end
  end

  // output register, loaded only on read slots
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rd_q_o <= '0;
    else if (rd_en_i) rd_q_o <= mem[rd_addr_i];
  end

  a_r1_rw_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && rd_en_i));
endmodule

// File: rtl/nt_sram.sv
module nt_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DATA_W = LANES * LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cke_ni,
  input  logic              ce0_ni,
  input  logic              ce1_i,
  input  logic              ce2_ni,
  input  logic              adv_i,
  input  logic              we_ni,
  input  logic [LANES-1:0]  bw_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lin_burst_i,
  input  logic [DATA_W-1:0] d_i,
  input  logic              oe_ni,
  input  logic              sleep_i,
  output logic [DATA_W-1:0] q_o,
  output logic              q_en_o
);
  logic en, sel, load, adv_go, go;
  logic burst_act_q, burst_we_q;
  logic [ADDR_W-1:0] cur_addr;

  logic              s1_vld_q, s1_we_q, s2_vld_q, s2_we_q, q_vld_q;
  logic [ADDR_W-1:0] s1_addr_q, s2_addr_q;
  logic [LANES-1:0]  s1_be_q, s2_be_q;
  logic [DATA_W-1:0] rd_q;

  assign en     = ~cke_ni;
  assign sel    = ~ce0_ni & ce1_i & ~ce2_ni & ~sleep_i;
  assign load   = ~adv_i & sel;
  assign adv_go = adv_i & burst_act_q & ~sleep_i;
  assign go     = load | adv_go;

  nt_sram_burst #(.ADDR_W(ADDR_W)) u_burst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (en),
    .load_i   (load),
    .adv_i    (adv_go),
    .linear_i (lin_burst_i),
    .addr_i   (addr_i),
    .addr_o   (cur_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      burst_act_q <= 1'b0;
      burst_we_q  <= 1'b0;
    end else if (en && !adv_i) begin
      burst_act_q <= sel;
      if (sel) burst_we_q <= ~we_ni;
    end
  end

  // two-stage command pipe: write data lands in the same slot as read data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld_q <= 1'b0; s1_we_q <= 1'b0; s1_addr_q <= '0; s1_be_q <= '0;
      s2_vld_q <= 1'b0; s2_we_q <= 1'b0; s2_addr_q <= '0; s2_be_q <= '0;
      q_vld_q  <= 1'b0;
    end else if (en) begin
      s1_vld_q  <= go;
      s1_we_q   <= load ? ~we_ni : burst_we_q;
      s1_addr_q <= cur_addr;
      s1_be_q   <= ~bw_ni;
      s2_vld_q  <= s1_vld_q;
      s2_we_q   <= s1_we_q;
      s2_addr_q <= s1_addr_q;
      s2_be_q   <= s1_be_q;
      q_vld_q   <= s2_vld_q & ~s2_we_q;
    end
  end

  nt_sram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (en & s2_vld_q & s2_we_q),
    .wr_addr_i (s2_addr_q),
    .wr_be_i   (s2_be_q),
    .wr_data_i (d_i),
    .rd_en_i   (en & s2_vld_q & ~s2_we_q),
    .rd_addr_i (s2_addr_q),
    .rd_q_o    (rd_q)
  );

  assign q_en_o = q_vld_q & ~oe_ni & ~sleep_i;
  assign q_o    = q_en_o ? rd_q : '0;

  a_r5_cke_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cke_ni |=> ($stable(s2_vld_q) && $stable(s2_addr_q) && $stable(q_vld_q) && $stable(rd_q)));
  a_r4_desel_bubble: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && !adv_i && (ce0_ni || !ce1_i || ce2_ni)) |=> !s1_vld_q);
  a_r7_sleep_blocks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && sleep_i) |=> !s1_vld_q);
  a_r1_write_slot_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cke_ni && s2_vld_q && s2_we_q) |=> !q_en_o);
endmodule

// File: tb/nt_sram_tb.sv
module nt_sram_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OP_DES = 0, OP_RD = 1, OP_WR = 2, OP_ADV = 3;

  logic        clk_i = 0, rst_ni = 0, cke_ni = 0, ce0_ni = 0, ce1_i = 0, ce2_ni = 0;
  logic        adv_i = 0, we_ni = 1, lin_burst_i = 1, oe_ni = 0, sleep_i = 0;
  logic [3:0]  bw_ni = 4'hF;
  logic [9:0]  addr_i = '0;
  logic [35:0] d_i = '0, q_o;
  logic        q_en_o;
  int          n_run = 0, n_fail = 0;

  nt_sram u_dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  localparam logic [35:0] A5 = 36'h123456789, A6 = 36'hABCDEF012, B6 = 36'h55555AAAA;
  localparam logic [35:0] M6 = {A6[35:18], B6[17:0]};

  typedef struct packed {
    logic [1:0]  op;
    logic [9:0]  a;
    logic [3:0]  ben;
    logic [35:0] d;
    logic        en;
    logic [35:0] q;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{2'd2, 10'd5, 4'h0, 36'h0, 1'b0, 36'h0},
    '{2'd2, 10'd6, 4'h0, 36'h0, 1'b0, 36'h0},
    '{2'd1, 10'd5, 4'hF, A5,    1'b0, 36'h0},
    '{2'd2, 10'd6, 4'hC, A6,    1'b0, 36'h0},
    '{2'd1, 10'd6, 4'hF, 36'h0, 1'b1, A5},
    '{2'd0, 10'd0, 4'hF, B6,    1'b0, 36'h0},
    '{2'd1, 10'd5, 4'hF, 36'h0, 1'b1, M6},
    '{2'd0, 10'd0, 4'hF, 36'h0, 1'b0, 36'h0},
    '{2'd0, 10'd0, 4'hF, 36'h0, 1'b1, A5},
    '{2'd0, 10'd0, 4'hF, 36'h0, 1'b0, 36'h0},
    '{2'd0, 10'd0, 4'hF, 36'h0, 1'b0, 36'h0}
  };

  task automatic cmd(input int op, input logic [9:0] a, input logic [3:0] ben,
                     input logic [35:0] d);
    adv_i = (op == OP_ADV); ce1_i = (op != OP_DES); we_ni = (op != OP_WR);
    addr_i = a; bw_ni = ben; d_i = d;
    @(posedge clk_i); #2;
  endtask

  task automatic chk(input string req, input logic en_exp, input logic [35:0] q_exp);
    n_run++;
    if (q_en_o !== en_exp || q_o !== q_exp) begin
      n_fail++;
      $display("FAIL %s: en=%b q=%h expected en=%b q=%h", req, q_en_o, q_o, en_exp, q_exp);
    end
  endtask

  task automatic rd_chk(input string req, input logic [9:0] a, input logic [35:0] exp);
    cmd(OP_RD, a, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0);
    chk(req, 1'b1, exp);
  endtask

  function automatic logic [35:0] pat(input int k);
    return 36'h0F1E2D3C4 ^ (36'h111111111 * k);
  endfunction

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 3 + 2);
    chk("R9 reset", 1'b0, '0);
    rst_ni = 1;
    @(posedge clk_i); #2;
    chk("R9 after release", 1'b0, '0);

    // R1 R2 R3 R4: mixed traffic table, no idle cycles between reads and writes
    for (int i = 0; i < 11; i++) begin
      cmd(int'(VEC[i].op), VEC[i].a, VEC[i].ben, VEC[i].d);
      chk($sformatf("R1/R2/R3 vec %0d", i), VEC[i].en, VEC[i].q);
    end

    // R4: each chip select alone deselects
    ce0_ni = 1; cmd(OP_RD, 10'd5, 4'hF, '0); ce0_ni = 0;
    cmd(OP_DES, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0);
    chk("R4 ce0_ni high", 1'b0, '0);
    ce2_ni = 1; cmd(OP_RD, 10'd5, 4'hF, '0); ce2_ni = 0;
    cmd(OP_DES, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0);
    chk("R4 ce2_ni high", 1'b0, '0);
    rd_chk("R4 all selected", 10'd5, A5);

    // R5: suspended edges do nothing, then pipeline resumes
    cmd(OP_RD, 10'd6, 4'hF, '0);
    cke_ni = 1;
    cmd(OP_WR, 10'd5, 4'h0, pat(9)); cmd(OP_DES, '0, 4'hF, pat(9)); cmd(OP_DES, '0, 4'hF, '0);
    chk("R5 suspended no output", 1'b0, '0);
    cke_ni = 0;
    cmd(OP_DES, '0, 4'hF, '0);
    chk("R5 one enabled edge", 1'b0, '0);
    cmd(OP_DES, '0, 4'hF, '0);
    chk("R5 data after two enabled edges", 1'b1, M6);
    cke_ni = 1;
    cmd(OP_DES, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0);
    chk("R5 output held", 1'b1, M6);

    // R6, R7: asynchronous masking of held data
    oe_ni = 1; #1; chk("R6 oe off", 1'b0, '0);
    oe_ni = 0; #1; chk("R6 oe back on", 1'b1, M6);
    sleep_i = 1; #1; chk("R7 sleep off", 1'b0, '0);
    sleep_i = 0; #1; chk("R7 sleep released", 1'b1, M6);
    cke_ni = 0;
    rd_chk("R5 suspended write ignored", 10'd5, A5);

    // R7: command sampled during sleep is dropped
    sleep_i = 1; cmd(OP_RD, 10'd5, 4'hF, '0); sleep_i = 0;
    cmd(OP_DES, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0);
    chk("R7 command dropped", 1'b0, '0);

    // R8: linear write burst from 0x12 -> 12,13,10,11
    lin_burst_i = 1;
    cmd(OP_WR, 10'h012, 4'h0, '0);
    cmd(OP_ADV, '0, 4'h0, '0);
    cmd(OP_ADV, '0, 4'h0, pat(0));
    cmd(OP_ADV, '0, 4'h0, pat(1));
    cmd(OP_DES, '0, 4'hF, pat(2));
    cmd(OP_DES, '0, 4'hF, pat(3));
    rd_chk("R8 linear beat2 wraps", 10'h010, pat(2));
    rd_chk("R8 linear beat3", 10'h011, pat(3));
    // linear read burst
    cmd(OP_RD, 10'h012, 4'hF, '0);
    cmd(OP_ADV, '0, 4'hF, '0);
    cmd(OP_ADV, '0, 4'hF, '0); chk("R8 read burst beat0", 1'b1, pat(0));
    cmd(OP_ADV, '0, 4'hF, '0); chk("R8 read burst beat1", 1'b1, pat(1));
    cmd(OP_DES, '0, 4'hF, '0); chk("R8 read burst beat2", 1'b1, pat(2));
    cmd(OP_DES, '0, 4'hF, '0); chk("R8 read burst beat3", 1'b1, pat(3));

    // R8: interleaved write burst from 0x21 -> 21,20,23,22
    lin_burst_i = 0;
    cmd(OP_WR, 10'h021, 4'h0, '0);
    cmd(OP_ADV, '0, 4'h0, '0);
    cmd(OP_ADV, '0, 4'h0, pat(4));
    cmd(OP_ADV, '0, 4'h0, pat(5));
    cmd(OP_DES, '0, 4'hF, pat(6));
    cmd(OP_DES, '0, 4'hF, pat(7));
    rd_chk("R8 interleave beat1", 10'h020, pat(5));
    rd_chk("R8 interleave beat2", 10'h023, pat(6));
    rd_chk("R8 interleave beat3", 10'h022, pat(7));

    // R8: advance after a bubble does nothing
    cmd(OP_DES, '0, 4'hF, '0);
    cmd(OP_ADV, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0); cmd(OP_DES, '0, 4'hF, '0);
    chk("R8 advance after bubble", 1'b0, '0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule